// File: doc/BRIEF.md
# Pipelined Fractional Complex Multiplier

This block forms the product of two complex operands X = xr + j·xi and Y = yr + j·yi, each part a 16-bit two's complement fraction, and keeps the full 32-bit real and imaginary results. It accepts a new operand pair on every clock. Each operand register has its own active-low load enable, and the imaginary part of either operand can be negated on its way in, so a conjugate product costs no extra cycle.

Four partial products are formed in parallel and registered. A subtractor then builds the real part and an adder builds the imaginary part. A selectable scale stage follows them and raises an overflow flag. Rounding is applied after the output register. A combinational field selector then places any two 16-bit halves of the result on the two output ports, so a caller can read the whole 64-bit complex result within a single cycle.

Top module: `cplx_frac_mul`

## Requirements
- R1: With no scaling, the 32-bit real result equals xr·yr − xi·yi and the 32-bit imaginary result equals xr·yi + xi·yr. Each product is taken as a 31-bit signed value and sign-extended, so the result LSB weighs 2^-30.
- R2: A partial product whose two operands are both 16'h8000 is replaced by the largest positive 31-bit value, 31'h3FFFFFFF.
- R3: When conj_x (or conj_y) is high on the edge that loads that operand, its imaginary part is stored negated. Negating 16'h8000 gives 16'h7FFF.
- R4: While x_en_n (y_en_n) is high, the X (Y) operand register keeps its value and new data on that port has no effect on the result.
- R5: shift_sel is sampled on the edge that loads the result. The codes are: 2'b11 shifts left by one with zero fill, 2'b00 passes the value unchanged, 2'b01 shifts arithmetically right by one, and 2'b10 shifts arithmetically right by two. The same shift applies to both parts.
- R6: ovf is high for a result exactly when shift_sel was 2'b11 and, in the real or the imaginary unscaled sum, bit 31 differs from bit 30.
- R7: When round_en is high, bit 16 of both scaled results reads as 1 and bits 15:0 are unchanged. The input acts without a clock.
- R8: out_sel acts without a clock. It selects (out_r, out_i) as follows: 2'b00 gives (real[31:16], imag[31:16]), 2'b01 gives (real[15:0], imag[15:0]), 2'b10 gives (real[31:16], real[15:0]), and 2'b11 gives (imag[31:16], imag[15:0]).
- R9: Data applied before a rising edge appears on the outputs after the third rising edge, counting that edge. A new operand pair is accepted on every cycle.
- R10: While rst_n is low, all registers clear, so every output field reads zero and ovf is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xr | input | 16 | Real part of X |
| xi | input | 16 | Imaginary part of X |
| yr | input | 16 | Real part of Y |
| yi | input | 16 | Imaginary part of Y |
| x_en_n | input | 1 | X register load enable, active low |
| y_en_n | input | 1 | Y register load enable, active low |
| conj_x | input | 1 | Negate xi on load |
| conj_y | input | 1 | Negate yi on load |
| shift_sel | input | 2 | Result scaling code |
| round_en | input | 1 | Force bit 16 of both results high |
| out_sel | input | 2 | Output field select |
| out_r | output | 16 | First output field |
| out_i | output | 16 | Second output field |
| ovf | output | 1 | Left-shift overflow flag |

## Verification
The assertions check four things on every cycle. The flag never rises unless the left-shift code was used. The outputs stay frozen while both operand registers hold. A (−1)·(−1) load with zero imaginary parts arrives as the saturated value exactly three edges later. The rounding bit shows whenever it is enabled. The arithmetic is left to the bench's scenarios: the sign handling across mixed-sign operands, the saturated conjugation of the minimum value, each scaling code, the field selector's four mappings and back-to-back streaming can only be compared against expected values worked out from the requirements.

// File: rtl/cplx_frac_mul.sv
module cplx_frac_mul #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] xr,
  input  logic [W-1:0] xi,
  input  logic [W-1:0] yr,
  input  logic [W-1:0] yi,
  input  logic         x_en_n,
  input  logic         y_en_n,
  input  logic         conj_x,
  input  logic         conj_y,
  input  logic [1:0]   shift_sel,
  input  logic         round_en,
  input  logic [1:0]   out_sel,
  output logic [W-1:0] out_r,
  output logic [W-1:0] out_i,
  output logic         ovf
);
  localparam int PW = 2*W - 1;
  localparam int RW = 2*W;
  localparam logic [W-1:0]  MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]  MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [PW-1:0] PMAX = {1'b0, {(PW-1){1'b1}}};

  function automatic logic [W-1:0] neg_sat(input logic [W-1:0] v);
    return (v == MINV) ? MAXV : (~v + 1'b1);
  endfunction

  function automatic logic [RW-1:0] scale(input logic [RW-1:0] v, input logic [1:0] c);
    case (c)
      2'b11:   scale = {v[RW-2:0], 1'b0};
      2'b01:   scale = $signed(v) >>> 1;
      2'b10:   scale = $signed(v) >>> 2;
      default: scale = v;
    endcase
  endfunction

  logic [W-1:0] xr_q, xi_q, yr_q, yi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      xr_q <= '0; xi_q <= '0;
    end else if (!x_en_n) begin
      xr_q <= xr;
      xi_q <= conj_x ? neg_sat(xi) : xi;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      yr_q <= '0; yi_q <= '0;
    end else if (!y_en_n) begin
      yr_q <= yr;
      yi_q <= conj_y ? neg_sat(yi) : yi;
    end

  // partial products: 0 = xr*yr, 1 = xr*yi, 2 = xi*yr, 3 = xi*yi
  logic [W-1:0] opa [4];
  logic [W-1:0] opb [4];
  assign opa[0] = xr_q; assign opb[0] = yr_q;
  assign opa[1] = xr_q; assign opb[1] = yi_q;
  assign opa[2] = xi_q; assign opb[2] = yr_q;
  assign opa[3] = xi_q; assign opb[3] = yi_q;

  for (genvar g = 0; g < 4; g++) begin : g_mul
    logic signed [PW-1:0] ea, eb, full;
    logic                 trap;
    logic [PW-1:0]        p_q;
    assign ea   = $signed({{(PW-W){opa[g][W-1]}}, opa[g]});
    assign eb   = $signed({{(PW-W){opb[g][W-1]}}, opb[g]});
    assign full = ea * eb;
    assign trap = (opa[g] == MINV) && (opb[g] == MINV);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) p_q <= '0;
      else        p_q <= trap ? PMAX : full;
  end

  logic [RW-1:0] sum_r, sum_i, res_r, res_i, rnd_r, rnd_i, rbit;
  logic          ovf_d;

  assign sum_r = {g_mul[0].p_q[PW-1], g_mul[0].p_q} - {g_mul[3].p_q[PW-1], g_mul[3].p_q};
  assign sum_i = {g_mul[1].p_q[PW-1], g_mul[1].p_q} + {g_mul[2].p_q[PW-1], g_mul[2].p_q};
  assign ovf_d = (shift_sel == 2'b11) &&
                 ((sum_r[RW-1] ^ sum_r[RW-2]) || (sum_i[RW-1] ^ sum_i[RW-2]));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      res_r <= '0; res_i <= '0; ovf <= 1'b0;
    end else begin
      res_r <= scale(sum_r, shift_sel);
      res_i <= scale(sum_i, shift_sel);
      ovf   <= ovf_d;
    end

  assign rbit  = {{(W-1){1'b0}}, round_en, {W{1'b0}}};
  assign rnd_r = res_r | rbit;
  assign rnd_i = res_i | rbit;

  always_comb
    case (out_sel)
      2'b00:   begin out_r = rnd_r[RW-1:W]; out_i = rnd_i[RW-1:W]; end
      2'b01:   begin out_r = rnd_r[W-1:0];  out_i = rnd_i[W-1:0];  end
      2'b10:   begin out_r = rnd_r[RW-1:W]; out_i = rnd_r[W-1:0];  end
      default: begin out_r = rnd_i[RW-1:W]; out_i = rnd_i[W-1:0];  end
    endcase
endmodule

module cplx_frac_mul_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] xr,
  input logic [W-1:0] xi,
  input logic [W-1:0] yr,
  input logic [W-1:0] yi,
  input logic         x_en_n,
  input logic         y_en_n,
  input logic [1:0]   shift_sel,
  input logic         round_en,
  input logic [1:0]   out_sel,
  input logic [W-1:0] out_r,
  input logic [W-1:0] out_i,
  input logic         ovf
);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] HIMX = {2'b00, {(W-2){1'b1}}};

  AST_OVF_LEFT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> ($past(shift_sel) == 2'b11)); // R6

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(x_en_n, 3) && $past(y_en_n, 3) && ($past(shift_sel, 1) == $past(shift_sel, 2))
     && $stable(out_sel) && $stable(round_en))
    |-> ($stable(out_r) && $stable(out_i))); // R4

  AST_TRAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && !$past(x_en_n, 3) && !$past(y_en_n, 3) &&
     ($past(xr, 3) == MINV) && ($past(yr, 3) == MINV) &&
     ($past(xi, 3) == '0) && ($past(yi, 3) == '0) &&
     ($past(shift_sel) == 2'b00) && (out_sel == 2'b00) && !round_en)
    |-> ((out_r == HIMX) && (out_i == '0))); // R2

  AST_ROUND_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (round_en && (out_sel == 2'b00)) |-> (out_r[0] && out_i[0])); // R7
endmodule

bind cplx_frac_mul cplx_frac_mul_chk #(.W(W)) u_chk (.*);

// File: tb/sim_cplx_frac_mul.sv
module sim_cplx_frac_mul;
  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] xr, xi, yr, yi;
  logic x_en_n, y_en_n, conj_x, conj_y, round_en;
  logic [1:0] shift_sel, out_sel;
  logic [15:0] out_r, out_i;
  logic ovf;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  cplx_frac_mul u0 (
    .clk(clk), .rst_n(rst_n), .xr(xr), .xi(xi), .yr(yr), .yi(yi),
    .x_en_n(x_en_n), .y_en_n(y_en_n), .conj_x(conj_x), .conj_y(conj_y),
    .shift_sel(shift_sel), .round_en(round_en), .out_sel(out_sel),
    .out_r(out_r), .out_i(out_i), .ovf(ovf)
  );

  function automatic logic signed [31:0] pm(input logic [15:0] a, input logic [15:0] b);
    logic signed [31:0] ea, eb;
    if (a == 16'h8000 && b == 16'h8000) return 32'sh3FFFFFFF;
    ea = $signed(a);
    eb = $signed(b);
    return ea * eb;
  endfunction

  function automatic logic [15:0] negs(input logic [15:0] v);
    return (v == 16'h8000) ? 16'h7FFF : (16'h0000 - v);
  endfunction

  function automatic logic [31:0] shv(input logic [31:0] v, input logic [1:0] c);
    case (c)
      2'b11: return v << 1;
      2'b01: return {v[31], v[31:1]};
      2'b10: return {v[31], v[31], v[31:2]};
      default: return v;
    endcase
  endfunction

  task automatic model(input logic [15:0] a_r, a_i, b_r, b_i, input logic cx, cy,
                       input logic [1:0] sh, output logic [31:0] er, ei, output logic eo);
    logic [15:0] ai, bi;
    logic signed [31:0] s_r, s_i;
    ai = cx ? negs(a_i) : a_i;
    bi = cy ? negs(b_i) : b_i;
    s_r = pm(a_r, b_r) - pm(ai, bi);
    s_i = pm(a_r, bi) + pm(ai, b_r);
    eo = (sh == 2'b11) && ((s_r[31] ^ s_r[30]) || (s_i[31] ^ s_i[30]));
    er = shv(s_r, sh);
    ei = shv(s_i, sh);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic get(output logic [31:0] r32, output logic [31:0] i32);
    out_sel = 2'b00; #1;
    r32[31:16] = out_r; i32[31:16] = out_i;
    out_sel = 2'b01; #1;
    r32[15:0] = out_r; i32[15:0] = out_i;
    out_sel = 2'b00;
  endtask

  task automatic drive(input logic [15:0] a_r, a_i, b_r, b_i, input logic cx, cy);
    xr = a_r; xi = a_i; yr = b_r; yi = b_i; conj_x = cx; conj_y = cy;
    x_en_n = 1'b0; y_en_n = 1'b0;
  endtask

  task automatic run_one(input string req, input logic [15:0] a_r, a_i, b_r, b_i,
                         input logic cx, cy, input logic [1:0] sh);
    logic [31:0] er, ei, ar, ai;
    logic eo;
    @(negedge clk);
    drive(a_r, a_i, b_r, b_i, cx, cy);
    shift_sel = sh;
    repeat (3) @(negedge clk);
    model(a_r, a_i, b_r, b_i, cx, cy, sh, er, ei, eo);
    get(ar, ai);
    chk({req, " real"}, ar, er);
    chk({req, " imag"}, ai, ei);
    chk({req, " ovf"}, {31'd0, ovf}, {31'd0, eo});
  endtask

  task automatic t_reset();
    logic [31:0] ar, ai;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    get(ar, ai);
    chk("R10 real after reset", ar, 32'd0);
    chk("R10 imag after reset", ai, 32'd0);
    chk("R10 ovf after reset", {31'd0, ovf}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    run_one("R1 half*half", 16'h4000, 16'h0000, 16'h4000, 16'h0000, 1'b0, 1'b0, 2'b00);
    run_one("R1 mixed signs", 16'h1234, 16'hF00D, 16'hC321, 16'h0777, 1'b0, 1'b0, 2'b00);
    run_one("R1 all negative", 16'h8001, 16'hA5A5, 16'hFFFF, 16'h9000, 1'b0, 1'b0, 2'b00);
    run_one("R1 pure imag", 16'h0000, 16'h2000, 16'h0000, 16'hE000, 1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_trap();
    run_one("R2 trap real", 16'h8000, 16'h0000, 16'h8000, 16'h0000, 1'b0, 1'b0, 2'b00);
    run_one("R2 trap both", 16'h8000, 16'h8000, 16'h8000, 16'h8000, 1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_conj();
    run_one("R3 conj x", 16'h1111, 16'h2345, 16'h3000, 16'hD000, 1'b1, 1'b0, 2'b00);
    run_one("R3 conj y", 16'h1111, 16'h2345, 16'h3000, 16'hD000, 1'b0, 1'b1, 2'b00);
    run_one("R3 conj x min sat", 16'h0100, 16'h8000, 16'h0200, 16'h0300, 1'b1, 1'b0, 2'b00);
  endtask

  task automatic t_enable();
    logic [31:0] er, ei, ar, ai;
    logic eo;
    run_one("R4 setup", 16'h2000, 16'h1000, 16'h0800, 16'hF800, 1'b0, 1'b0, 2'b00);
    @(negedge clk);
    x_en_n = 1'b1; y_en_n = 1'b1;
    xr = 16'h7000; xi = 16'h7000; yr = 16'h7000; yi = 16'h7000;
    repeat (4) @(negedge clk);
    model(16'h2000, 16'h1000, 16'h0800, 16'hF800, 1'b0, 1'b0, 2'b00, er, ei, eo);
    get(ar, ai);
    chk("R4 hold real", ar, er);
    chk("R4 hold imag", ai, ei);
    x_en_n = 1'b0;
    repeat (3) @(negedge clk);
    model(16'h7000, 16'h7000, 16'h0800, 16'hF800, 1'b0, 1'b0, 2'b00, er, ei, eo);
    get(ar, ai);
    chk("R4 x only real", ar, er);
    chk("R4 x only imag", ai, ei);
    y_en_n = 1'b0;
  endtask

  task automatic t_shift();
    for (int c = 0; c < 4; c++)
      run_one("R5 shift code", 16'h3000, 16'hE100, 16'h2468, 16'hC00F, 1'b0, 1'b0, 2'(c));
    run_one("R6 left overflow", 16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 1'b0, 1'b0, 2'b11);
    run_one("R6 no shift no flag", 16'h8000, 16'h8000, 16'h8000, 16'h7FFF, 1'b0, 1'b0, 2'b00);
  endtask

  task automatic t_round_sel();
    logic [31:0] er, ei, ar, ai;
    logic eo;
    run_one("R7 setup", 16'h0123, 16'h0045, 16'h0067, 16'h0011, 1'b0, 1'b0, 2'b00);
    model(16'h0123, 16'h0045, 16'h0067, 16'h0011, 1'b0, 1'b0, 2'b00, er, ei, eo);
    out_sel = 2'b10; #1;
    chk("R8 sel 10", {out_r, out_i}, er);
    out_sel = 2'b11; #1;
    chk("R8 sel 11", {out_r, out_i}, ei);
    round_en = 1'b1;
    get(ar, ai);
    chk("R7 round real", ar, er | 32'h0001_0000);
    chk("R7 round imag", ai, ei | 32'h0001_0000);
    round_en = 1'b0;
  endtask

  task automatic t_latency();
    logic [31:0] ea, eai, eb, ebi, ar, ai;
    logic eo;
    run_one("R9 setup", 16'h0400, 16'h0000, 16'h0400, 16'h0000, 1'b0, 1'b0, 2'b00);
    model(16'h0400, 16'h0000, 16'h0400, 16'h0000, 1'b0, 1'b0, 2'b00, ea, eai, eo);
    model(16'hF000, 16'h0100, 16'h0200, 16'h0300, 1'b0, 1'b0, 2'b00, eb, ebi, eo);
    drive(16'hF000, 16'h0100, 16'h0200, 16'h0300, 1'b0, 1'b0);
    @(negedge clk); get(ar, ai);
    chk("R9 one edge old", ar, ea);
    @(negedge clk); get(ar, ai);
    chk("R9 two edges old", ar, ea);
    @(negedge clk); get(ar, ai);
    chk("R9 three edges new", ar, eb);
    chk("R9 three edges new imag", ai, ebi);
  endtask

  task automatic t_stream();
    logic [15:0] va [4] = '{16'h1000, 16'hE000, 16'h7FFF, 16'h8000};
    logic [15:0] vb [4] = '{16'h0F00, 16'h2222, 16'h8000, 16'h8000};
    logic [31:0] er [4];
    logic [31:0] ei [4];
    logic [31:0] ar, ai;
    logic eo;
    for (int k = 0; k < 4; k++)
      model(va[k], vb[k], vb[k], va[k], 1'b0, 1'b0, 2'b00, er[k], ei[k], eo);
    @(negedge clk);
    for (int k = 0; k < 7; k++) begin
      if (k >= 3) begin
        get(ar, ai);
        chk("R9 stream real", ar, er[k-3]);
        chk("R9 stream imag", ai, ei[k-3]);
      end
      if (k < 4) drive(va[k], vb[k], vb[k], va[k], 1'b0, 1'b0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    xr = '0; xi = '0; yr = '0; yi = '0;
    x_en_n = 1'b0; y_en_n = 1'b0; conj_x = 1'b0; conj_y = 1'b0;
    shift_sel = 2'b00; round_en = 1'b0; out_sel = 2'b00;
    t_reset();
    t_basic();
    t_trap();
    t_conj();
    t_enable();
    t_shift();
    t_round_sel();
    t_latency();
    t_stream();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule